// File: doc/BRIEF.md
# Byte-Wide Host Port Register Bank

This block is the fabric-side slave of a byte-wide parallel host port. A host outside the chip moves addresses and data over one shared 8-bit bidirectional bus. Two active-low strobes mark the cycle type: one for an address cycle and one for a data cycle. A direction line chooses between reads and writes. The block answers every strobe on a wait line. The host raises a strobe, waits for wait to go high, takes or leaves the bus, releases the strobe, and waits for wait to fall before it starts the next cycle.

An address cycle loads an internal address pointer. The data cycles that follow act on the register the pointer selects. Host-written registers come out to the user logic as plain parallel outputs: 16 switch bits, 16 pushbutton bits and a 32-bit word toward the fabric. Values from the user logic go back to the host: 8 LED bits, a 24-bit light bar and a 32-bit word from the fabric. Each byte of a wide register has its own address, with the least significant byte at the lowest address. The strobes and the direction line are brought into the clock domain through two flip-flops.

Top module: `pport_regbank`

## Requirements
- R1: While reset is high and in the cycle after it, wait is low and the switch, pushbutton and fabric-bound outputs are all zero.
- R2: Wait rises on the third rising clock edge after a strobe goes low. It stays high as long as a strobe is held low, and it falls on the third rising edge after both strobes are high.
- R3: An address-strobe write loads the bus byte into the address pointer. An address-strobe read returns the pointer's value on the bus.
- R4: A data-strobe write to address 0..7 updates one byte of the host-written registers. Addresses 0 and 1 are switch bits [7:0] and [15:8], addresses 2 and 3 are pushbutton bits [7:0] and [15:8], and addresses 4..7 are fabric-bound word bytes 0..3 (bits [7:0] first).
- R5: A data-strobe read of address 8 returns the LED bits. Addresses 9..11 return light bar bytes 0..2, and addresses 12..15 return fabric-sourced word bytes 0..3, least significant byte first.
- R6: A data-strobe read of address 0..7 returns the byte last written to that address.
- R7: A data-strobe read of any address from 16 to 255 returns zero. A data-strobe write to any address from 8 to 255 leaves every host-written output unchanged.
- R8: The block drives the bus only while wait is high in answer to a read strobe. In every other cycle it leaves the bus high-impedance.
- R9: A strobe that is held low performs exactly one access, however long it is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| hbus_io | inout | 8 | Shared address/data byte bus |
| astb_n | input | 1 | Address strobe, active low |
| dstb_n | input | 1 | Data strobe, active low |
| rnw | input | 1 | 1 = host reads, 0 = host writes |
| wait_o | output | 1 | Handshake toward the host |
| sw_o | output | 16 | Host-written switch bits |
| pb_o | output | 16 | Host-written pushbutton bits |
| to_fab_o | output | 32 | Host-written word toward the fabric |
| led_i | input | 8 | LED bits the host reads |
| bar_i | input | 24 | Light bar bits the host reads |
| from_fab_i | input | 32 | Word from the fabric the host reads |

## Verification
Every data address from 0 to 255 is written with its own byte pattern. A byte that lands in the wrong lane, a write that reaches a read-only or unmapped location, and a decoder that aliases the upper addresses onto 0..15 each give a mismatch on the parallel outputs. All 256 addresses are then read back and compared with values worked out from the input patterns. This exposes swapped byte order in the wide read registers and non-zero data on unmapped reads. A second pass with complemented patterns catches bits stuck at one value. Directed cycles count the exact wait latency, hold a strobe low for many cycles to show that only one access occurs, and read back the address pointer.

// File: rtl/pport_pkg.sv
package pport_pkg;
  localparam int ADDR_W = 8;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [ADDR_W-1:0] addr_t;
endpackage

// File: rtl/pport_sync.sv
module pport_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '0;
    else     stage_q[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= '0;
      else     stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/pport_regfile.sv
module pport_regfile
  import pport_pkg::*;
#(
  parameter int WR_BYTES = 8,
  parameter int RD_BYTES = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we,
  input  addr_t                    addr,
  input  byte_t                    wdata,
  input  logic [RD_BYTES*8-1:0]    rd_vec,
  output logic [WR_BYTES*8-1:0]    wr_vec,
  output byte_t                    rdata
);
  localparam int RD_BASE = WR_BYTES;

  for (genvar i = 0; i < WR_BYTES; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)
        wr_vec[i*8 +: 8] <= '0;
      else if (we && addr == ADDR_W'(i))
        wr_vec[i*8 +: 8] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int j = 0; j < WR_BYTES; j++)
      if (addr == ADDR_W'(j)) rdata = wr_vec[j*8 +: 8];
    for (int k = 0; k < RD_BYTES; k++)
      if (addr == ADDR_W'(RD_BASE + k)) rdata = rd_vec[k*8 +: 8];
  end
endmodule

// File: rtl/pport_ctrl.sv
module pport_ctrl
  import pport_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  astb_s,
  input  logic  dstb_s,
  input  logic  rnw_s,
  input  byte_t bus_in,
  input  byte_t rdata,
  output logic  busy,
  output logic  bus_oe,
  output byte_t bus_out,
  output addr_t addr,
  output logic  we,
  output byte_t wdata
);
  logic go;
  logic idle_lines;

  assign go         = !busy && (astb_s || dstb_s);
  assign idle_lines = !astb_s && !dstb_s;
  assign we         = go && !astb_s && dstb_s && !rnw_s;
  assign wdata      = bus_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      bus_oe  <= 1'b0;
      bus_out <= '0;
      addr    <= '0;
    end else if (go) begin
      busy <= 1'b1;
      if (astb_s) begin
        if (rnw_s) begin
          bus_oe  <= 1'b1;
          bus_out <= addr;
        end else begin
          addr <= bus_in;
        end
      end else if (rnw_s) begin
        bus_oe  <= 1'b1;
        bus_out <= rdata;
      end
    end else if (busy && idle_lines) begin
      busy   <= 1'b0;
      bus_oe <= 1'b0;
    end
  end
endmodule

// File: rtl/pport_regbank.sv
module pport_regbank
  import pport_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int SW_W        = 16,
  parameter int PB_W        = 16,
  parameter int TF_W        = 32,
  parameter int LED_W       = 8,
  parameter int BAR_W       = 24,
  parameter int FF_W        = 32
) (
  input  logic              clk,
  input  logic              rst,
  inout  wire  [7:0]        hbus_io,
  input  logic              astb_n,
  input  logic              dstb_n,
  input  logic              rnw,
  output logic              wait_o,
  output logic [SW_W-1:0]   sw_o,
  output logic [PB_W-1:0]   pb_o,
  output logic [TF_W-1:0]   to_fab_o,
  input  logic [LED_W-1:0]  led_i,
  input  logic [BAR_W-1:0]  bar_i,
  input  logic [FF_W-1:0]   from_fab_i
);
  localparam int WR_W     = SW_W + PB_W + TF_W;
  localparam int RD_W     = LED_W + BAR_W + FF_W;
  localparam int WR_BYTES = WR_W / 8;
  localparam int RD_BYTES = RD_W / 8;

  logic [2:0]      line_s;
  logic            astb_s, dstb_s, rnw_s;
  logic            busy, bus_oe, wr_en;
  byte_t           bus_out, wdata, rdata;
  addr_t           cur_addr;
  logic [WR_W-1:0] wr_vec;

  pport_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .d({rnw, ~dstb_n, ~astb_n}),
    .q(line_s)
  );
  assign {rnw_s, dstb_s, astb_s} = line_s;

  pport_ctrl u_ctrl (
    .clk(clk), .rst(rst),
    .astb_s(astb_s), .dstb_s(dstb_s), .rnw_s(rnw_s),
    .bus_in(hbus_io), .rdata(rdata),
    .busy(busy), .bus_oe(bus_oe), .bus_out(bus_out),
    .addr(cur_addr), .we(wr_en), .wdata(wdata)
  );

  pport_regfile #(.WR_BYTES(WR_BYTES), .RD_BYTES(RD_BYTES)) u_regs (
    .clk(clk), .rst(rst),
    .we(wr_en), .addr(cur_addr), .wdata(wdata),
    .rd_vec({from_fab_i, bar_i, led_i}),
    .wr_vec(wr_vec),
    .rdata(rdata)
  );

  assign hbus_io               = bus_oe ? bus_out : 8'bzzzz_zzzz;
  assign wait_o                = busy;
  assign {to_fab_o, pb_o, sw_o} = wr_vec;
endmodule

// File: rtl/pport_regbank_chk.sv
module pport_regbank_chk #(
  parameter int WR_W = 64
) (
  input logic            clk,
  input logic            rst,
  input logic            wait_o,
  input logic            astb_s,
  input logic            dstb_s,
  input logic            bus_oe,
  input logic            wr_en,
  input logic [WR_W-1:0] wr_vec
);
  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (!wait_o && wr_vec == '0));

  assert_wait_rise_R2: assert property (@(posedge clk) disable iff (rst)
    (!wait_o && (astb_s || dstb_s)) |=> wait_o);

  assert_wait_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (wait_o && (astb_s || dstb_s)) |=> wait_o);

  assert_wait_fall_R2: assert property (@(posedge clk) disable iff (rst)
    (wait_o && !astb_s && !dstb_s) |=> !wait_o);

  assert_drive_in_window_R8: assert property (@(posedge clk) disable iff (rst)
    bus_oe |-> wait_o);

  assert_outputs_stable_R7: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(wr_vec));

  assert_single_access_R9: assert property (@(posedge clk) disable iff (rst)
    wait_o |-> !wr_en);
endmodule

bind pport_regbank pport_regbank_chk #(.WR_W(SW_W + PB_W + TF_W)) u_chk (
  .clk(clk), .rst(rst), .wait_o(wait_o),
  .astb_s(astb_s), .dstb_s(dstb_s),
  .bus_oe(bus_oe), .wr_en(wr_en), .wr_vec(wr_vec)
);

// File: tb/pport_regbank_bench.sv
module pport_regbank_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        astb_n = 1'b1, dstb_n = 1'b1, rnw = 1'b1;
  logic        host_oe = 1'b0;
  logic [7:0]  host_d = '0;
  wire  [7:0]  hbus;
  logic        wait_o;
  logic [15:0] sw_o, pb_o;
  logic [31:0] to_fab_o;
  logic [7:0]  led_i = '0;
  logic [23:0] bar_i = '0;
  logic [31:0] from_fab_i = '0;

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;
  int rise_n, fall_n;
  logic [7:0] model [8];

  assign hbus = host_oe ? host_d : 8'bzzzz_zzzz;

  always #5 clk = ~clk;

  pport_regbank u_pport_regbank (
    .clk(clk), .rst(rst), .hbus_io(hbus),
    .astb_n(astb_n), .dstb_n(dstb_n), .rnw(rnw),
    .wait_o(wait_o), .sw_o(sw_o), .pb_o(pb_o), .to_fab_o(to_fab_o),
    .led_i(led_i), .bar_i(bar_i), .from_fab_i(from_fab_i)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic xfer(input bit is_addr, input bit rd, input logic [7:0] wv,
                      input int hold, output logic [7:0] rv);
    int n;
    @(negedge clk);
    rnw = rd; host_d = wv; host_oe = !rd;
    if (is_addr) astb_n = 1'b0; else dstb_n = 1'b0;
    n = 0;
    while (!wait_o && n < 20) begin @(negedge clk); n++; end
    rise_n = n;
    if (!wait_o) chk(1'b0, "R2 rise timeout", 0, 1);
    rv = hbus;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      if (!wait_o) chk(1'b0, "R2 hold", 0, 1);
    end
    @(negedge clk);
    astb_n = 1'b1; dstb_n = 1'b1; host_oe = 1'b0;
    n = 0;
    while (wait_o && n < 20) begin @(negedge clk); n++; end
    fall_n = n;
    if (wait_o) chk(1'b0, "R2 fall timeout", 1, 0);
  endtask

  function automatic logic [7:0] exp_read(input int a);
    logic [63:0] rv;
    rv = {from_fab_i, bar_i, led_i};
    if (a < 8)       return model[a];
    else if (a < 16) return rv[(a-8)*8 +: 8];
    else             return 8'h00;
  endfunction

  task automatic check_outputs(input string req);
    chk(sw_o == {model[1], model[0]}, {req, " sw"}, sw_o, {model[1], model[0]});
    chk(pb_o == {model[3], model[2]}, {req, " pb"}, pb_o, {model[3], model[2]});
    chk(to_fab_o == {model[7], model[6], model[5], model[4]}, {req, " to_fab"},
        to_fab_o, {model[7], model[6], model[5], model[4]});
  endtask

  task automatic sweep(input logic [7:0] salt);
    logic [7:0] d, r;
    // R4 / R7: write every address, model only lanes 0..7
    for (int a = 0; a < 256; a++) begin
      d = 8'((a * 29 + 7)) ^ salt;
      xfer(1'b1, 1'b0, 8'(a), 0, r);
      xfer(1'b0, 1'b0, d, 0, r);
      if (a < 8) model[a] = d;
      if (a == 7 || a == 15 || a == 255) check_outputs(a < 8 ? "R4" : "R7");
    end
    // R5 / R6 / R7 reads of every address
    for (int a = 0; a < 256; a++) begin
      xfer(1'b1, 1'b0, 8'(a), 0, r);
      xfer(1'b0, 1'b1, 8'h00, 0, r);
      chk(r == exp_read(a), a < 8 ? "R6 readback" : (a < 16 ? "R5 read" : "R7 unmapped read"),
          r, exp_read(a));
    end
  endtask

  initial begin
    logic [7:0] r;
    for (int i = 0; i < 8; i++) model[i] = 8'h00;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk(wait_o == 1'b0, "R1 wait", wait_o, 0);
    check_outputs("R1");
    rst = 1'b0;
    @(negedge clk);
    chk(wait_o == 1'b0, "R1 wait after reset", wait_o, 0);
    check_outputs("R1");

    // R2 exact latency, R3 pointer read-back
    xfer(1'b1, 1'b0, 8'h5A, 0, r);
    chk(rise_n == 3, "R2 rise latency", rise_n, 3);
    chk(fall_n == 3, "R2 fall latency", fall_n, 3);
    xfer(1'b1, 1'b1, 8'h00, 0, r);
    chk(r == 8'h5A, "R3 pointer read", r, 8'h5A);
    xfer(1'b1, 1'b0, 8'hC3, 0, r);
    xfer(1'b1, 1'b1, 8'h00, 0, r);
    chk(r == 8'hC3, "R3 pointer read", r, 8'hC3);

    // R9: long-held write strobe gives one access; then read back
    xfer(1'b1, 1'b0, 8'h02, 0, r);
    xfer(1'b0, 1'b0, 8'h9E, 12, r);
    model[2] = 8'h9E;
    check_outputs("R9");
    xfer(1'b0, 1'b1, 8'h00, 12, r);
    chk(r == 8'h9E, "R9 held read", r, 8'h9E);

    led_i = 8'hA7; bar_i = 24'h13_57_9B; from_fab_i = 32'hDEAD_F00D;
    sweep(8'h00);
    led_i = ~led_i; bar_i = ~bar_i; from_fab_i = ~from_fab_i;
    sweep(8'hFF);

    // R8: after reads the host can drive the bus cleanly
    xfer(1'b1, 1'b0, 8'h04, 0, r);
    xfer(1'b0, 1'b0, 8'h3C, 0, r);
    model[4] = 8'h3C;
    check_outputs("R8");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule